// File: doc/BRIEF.md
# Audio Serial Clock Divider

This block produces the three clocks of a serial audio link: a master clock, a bit clock and a frame (left/right) clock. It runs from a reference clock at twice the master rate and carries the master phase in a free-running phase counter, so every output is a plain register and never a gated clock. A two-bit speed code picks how many master periods make up one bit period. The frame clock is always the bit clock divided by 64. All three outputs fall together at the start of every frame.

Each output has its own disable input. An enable or disable request takes effect only at a falling edge of the output concerned, so a change never cuts a pulse short. A new speed code is adopted only at the point where every output falls at once, so no output ever shows a partial period. A two-bit master-frequency family code goes through the block to a status output and does not touch the clocks.

Top module: `audio_clkdiv`

## Requirements
- R1: While `rst_ni` is low at a rising edge of `clk_i`, the phase is cleared, the speed code becomes 00, all three outputs are turned off, and all outputs and `fam_o` read 0.
- R2: When enabled, `mclk_o` is high for one reference cycle and low for the next, so its period is two reference cycles with 50 percent duty.
- R3: Speed codes 00, 01, 10 and 11 make the bit clock the master clock divided by 8, 4, 2 and 1. Each half-period is a whole number of reference cycles. In code 11, `bclk_o` is identical to the master waveform.
- R4: In every speed mode, `frm_o` is the bit clock divided by 64 with 50 percent duty: 64 bit-clock falling edges per frame period.
- R5: The three outputs fall together at the start of each frame, and `frm_o` changes only at a falling edge of the bit clock.
- R6: Disable bit 0 controls `mclk_o`, bit 1 controls `bclk_o` and bit 2 controls `frm_o`. A disabled output stays low.
- R7: An output samples its disable bit only at its own falling edge and holds the result until its next falling edge. As a result, every high pulse on an output lasts exactly one half-period of the mode in force.
- R8: `mode_i` is sampled only in the cycle where the 10-bit phase wraps to zero. This happens every 1024 reference cycles and is a common falling point. The old mode stays in force until that point.
- R9: `fam_o` equals `fam_i` one reference cycle later and has no effect on any clock output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock at twice the master clock rate |
| rst_ni | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Speed code; 00 gives master/8 as bit clock, 11 gives master/1 |
| dis_i | input | 3 | Per-output disable: bit 0 master, bit 1 bit clock, bit 2 frame clock |
| fam_i | input | 2 | Master frequency family code (00, 01, 1x) |
| mclk_o | output | 1 | Master clock output |
| bclk_o | output | 1 | Bit clock output |
| frm_o | output | 1 | Frame (left/right) clock output |
| fam_o | output | 2 | Registered copy of the family code |

## Verification
The assertions assume `rst_ni` is held low from time zero through at least one rising edge. They also assume `mode_i`, `dis_i` and `fam_i` change only away from the rising edge. They assume nothing else about the timing of those inputs: a new speed code or disable request may arrive in any cycle, since the block defers it to a safe point itself. The stimulus drives every input on the falling edge of the reference. It moves the speed code and the disable bits at arbitrary phases, including bursts of disable toggling shorter than one bit period, to show that deferral alone keeps the waveforms whole.

// File: rtl/audio_clkdiv_pkg.sv
// Package: shared indices and types of the audio clock divider.
// Assumes three outputs in a fixed order: master, bit, frame.
package audio_clkdiv_pkg;

    typedef logic [1:0] speed_t;

    localparam int OUT_MST = 0;
    localparam int OUT_BIT = 1;
    localparam int OUT_FRM = 2;
    localparam int NUM_OUT = 3;

    localparam speed_t SPEED_RESET = 2'b00;

endpackage

// File: rtl/acd_phase.sv
// Phase counter of the divider.
// Counts reference cycles. Bit 0 of the count is the master phase.
// The speed code is adopted only when the count wraps to zero. That is
// the one instant where every derived clock falls together.
// Assumes: synchronous active-low reset.
module acd_phase
    import audio_clkdiv_pkg::*;
#(
    parameter int PH_W = 10
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  speed_t          mode_i,
    output logic [PH_W-1:0] ph_q,
    output logic [PH_W-1:0] ph_nxt,
    output speed_t          mode_q,
    output speed_t          mode_nxt
);

    logic wrap;

    // Next-state view: the count advances, and the mode is taken on wrap.
    always_comb begin
        wrap     = &ph_q;
        ph_nxt   = ph_q + PH_W'(1);
        mode_nxt = wrap ? mode_i : mode_q;
    end

    // Phase and committed speed code registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ph_q   <= '0;
            mode_q <= SPEED_RESET;
        end else begin
            ph_q   <= ph_nxt;
            mode_q <= mode_nxt;
        end
    end

endmodule

// File: rtl/acd_levels.sv
// Raw level selector.
// Maps a phase value and a speed code to the ungated levels of the three
// clocks. The master level is phase bit 0. The bit clock is the phase bit
// BD_LOG - mode, and the frame clock is FB_LOG bits above it. A level is
// high in the upper half of its own count, so every clock falls when its
// low-order bits wrap.
// Assumes: BD_LOG >= 3, so that all four speed codes select a valid bit.
module acd_levels
    import audio_clkdiv_pkg::*;
#(
    parameter int BD_LOG = 3,
    parameter int FB_LOG = 6,
    parameter int PH_W   = 1 + BD_LOG + FB_LOG
) (
    input  logic [PH_W-1:0]    ph_i,
    input  speed_t             mode_i,
    output logic [NUM_OUT-1:0] lvl_o
);

    logic [PH_W-1:0] sh_bit;
    logic [PH_W-1:0] sh_frm;

    // Select one phase bit per clock by shifting it down to position 0.
    always_comb begin
        sh_bit         = ph_i >> (BD_LOG - int'(mode_i));
        sh_frm         = ph_i >> (BD_LOG + FB_LOG - int'(mode_i));
        lvl_o[OUT_MST] = ph_i[0];
        lvl_o[OUT_BIT] = sh_bit[0];
        lvl_o[OUT_FRM] = sh_frm[0];
    end

endmodule

// File: rtl/acd_gate.sv
// Glitch-free output gate for one clock.
// Registers the level of one clock. The enable is re-sampled only in the
// cycle where the raw level falls, so each high pulse is either whole or
// absent. A disabled output is driven low.
// Assumes: lvl_i is the level the output takes after the coming edge.
module acd_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    input  logic dis_i,
    output logic out_o
);

    logic raw_q;
    logic en_q;
    logic fall;
    logic en_nxt;

    // Detect the falling instant and compute the enable that follows it.
    always_comb begin
        fall   = raw_q & ~lvl_i;
        en_nxt = fall ? ~dis_i : en_q;
    end

    // Raw level, gate enable and gated output registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            raw_q <= 1'b0;
            en_q  <= 1'b0;
            out_o <= 1'b0;
        end else begin
            raw_q <= lvl_i;
            en_q  <= en_nxt;
            out_o <= lvl_i & en_nxt;
        end
    end

endmodule

// File: rtl/audio_clkdiv.sv
// Audio serial clock divider, top level.
// Derives the master, bit and frame clocks from a reference at twice the
// master rate. Each output is gated glitch-free under its own disable bit.
// The family code is carried to a status output.
// Assumes: synchronous active-low reset; all inputs are synchronous to clk_i.
module audio_clkdiv
    import audio_clkdiv_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    parameter int MAX_BDIV   = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic [2:0] dis_i,
    input  logic [1:0] fam_i,
    output logic       mclk_o,
    output logic       bclk_o,
    output logic       frm_o,
    output logic [1:0] fam_o
);

    localparam int FB_LOG = $clog2(FRAME_BITS);
    localparam int BD_LOG = $clog2(MAX_BDIV);
    localparam int PH_W   = 1 + BD_LOG + FB_LOG;

    logic [PH_W-1:0]    ph_q;
    logic [PH_W-1:0]    ph_nxt;
    speed_t             mode_q;
    speed_t             mode_nxt;
    logic [NUM_OUT-1:0] lvl;
    logic [NUM_OUT-1:0] gated;

    acd_phase #(.PH_W(PH_W)) u_phase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (mode_i),
        .ph_q     (ph_q),
        .ph_nxt   (ph_nxt),
        .mode_q   (mode_q),
        .mode_nxt (mode_nxt)
    );

    acd_levels #(.BD_LOG(BD_LOG), .FB_LOG(FB_LOG), .PH_W(PH_W)) u_levels (
        .ph_i   (ph_nxt),
        .mode_i (mode_nxt),
        .lvl_o  (lvl)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
        acd_gate u_gate (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .lvl_i  (lvl[g]),
            .dis_i  (dis_i[g]),
            .out_o  (gated[g])
        );
    end

    // Family code status register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) fam_o <= 2'b00;
        else         fam_o <= fam_i;
    end

    assign mclk_o = gated[OUT_MST];
    assign bclk_o = gated[OUT_BIT];
    assign frm_o  = gated[OUT_FRM];

endmodule

// File: rtl/acd_checker.sv
// Property checker for audio_clkdiv, attached through bind.
// Measures high-pulse lengths with counters instead of long $past chains.
module acd_checker #(
    parameter int BD_LOG = 3,
    parameter int FB_LOG = 6,
    parameter int PH_W   = 10
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            mclk_o,
    input logic            bclk_o,
    input logic            frm_o,
    input logic [1:0]      fam_i,
    input logic [1:0]      fam_o,
    input logic [1:0]      mode_q,
    input logic [PH_W-1:0] ph_q,
    input logic [2:0]      lvl
);

    logic            pb;
    logic            pf;
    logic [PH_W-1:0] blen;
    logic [PH_W-1:0] flen;
    logic [1:0]      bmode;
    logic [1:0]      fmode;

    // Count the length of each high pulse and note the mode at its rise.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pb    <= 1'b0;
            pf    <= 1'b0;
            blen  <= '0;
            flen  <= '0;
            bmode <= 2'b00;
            fmode <= 2'b00;
        end else begin
            pb <= bclk_o;
            pf <= frm_o;
            if (bclk_o) blen <= pb ? blen + PH_W'(1) : PH_W'(1);
            if (frm_o)  flen <= pf ? flen + PH_W'(1) : PH_W'(1);
            if (bclk_o && !pb) bmode <= mode_q;
            if (frm_o && !pf)  fmode <= mode_q;
        end
    end

    // R2: a master high pulse lasts exactly one reference cycle.
    a_r2_master_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mclk_o |=> !mclk_o);

    // R7: a bit-clock high pulse is never shortened.
    a_r7_bit_whole_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pb && !bclk_o) |-> (blen == (PH_W'(1) << (BD_LOG - int'(bmode)))));

    // R7: a frame high pulse is never shortened.
    a_r7_frame_whole_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pf && !frm_o) |-> (flen == (PH_W'(1) << (BD_LOG + FB_LOG - int'(fmode)))));

    // R5: the raw frame level moves only where the raw bit level falls.
    a_r5_frame_on_bit_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl[2] != $past(lvl[2])) |-> ($past(lvl[1]) && !lvl[1]));

    // R8: the committed speed code changes only at the phase wrap.
    a_r8_mode_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q != $past(mode_q)) |-> (ph_q == '0));

    // R9: the family code is copied one cycle later.
    a_r9_family_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (fam_o == $past(fam_i)));

endmodule

bind audio_clkdiv acd_checker #(.BD_LOG(BD_LOG), .FB_LOG(FB_LOG), .PH_W(PH_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mclk_o (mclk_o),
    .bclk_o (bclk_o),
    .frm_o  (frm_o),
    .fam_i  (fam_i),
    .fam_o  (fam_o),
    .mode_q (mode_q),
    .ph_q   (ph_q),
    .lvl    (lvl)
);

// File: tb/tb_audio_clkdiv.sv
module tb_audio_clkdiv;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_drv;
    logic [2:0] dis_drv;
    logic [1:0] fam_drv;
    logic       mclk, bclk, frm;
    logic [1:0] fam_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit run_chk   = 0;
    bit count_en  = 0;
    bit finished  = 0;

    // Reference model state
    logic [9:0] m_ph;
    logic [1:0] m_mode;
    logic [2:0] m_en;
    logic [2:0] m_raw;
    logic [2:0] m_exp;
    logic [1:0] m_fam;
    logic [2:0] r_lv;

    always #5 clk = ~clk;

    audio_clkdiv dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .mode_i (mode_drv),
        .dis_i  (dis_drv),
        .fam_i  (fam_drv),
        .mclk_o (mclk),
        .bclk_o (bclk),
        .frm_o  (frm),
        .fam_o  (fam_out)
    );

    // Levels of the three clocks for a phase and mode, from R2..R4.
    function automatic logic [2:0] ref_levels(input logic [9:0] ph, input logic [1:0] md);
        logic [2:0] r;
        r[0] = ph[0];
        r[1] = ph[3 - int'(md)];
        r[2] = ph[9 - int'(md)];
        return r;
    endfunction

    function automatic int bdiv(input logic [1:0] md);
        return 8 >> md;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = '0; m_mode = 2'b00; m_en = '0; m_raw = '0; m_exp = '0; m_fam = '0;
        end else begin
            if (m_ph == 10'h3ff) m_mode = mode_drv;
            m_ph = m_ph + 10'd1;
            r_lv = ref_levels(m_ph, m_mode);
            for (int i = 0; i < 3; i++)
                if (m_raw[i] && !r_lv[i]) m_en[i] = !dis_drv[i];
            m_raw = r_lv;
            m_exp = r_lv & m_en;
            m_fam = fam_drv;
        end
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    // Cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (run_chk && rst_n) begin
            check(mclk == m_exp[0], "R2 R6 R7 master", mclk, m_exp[0]);
            check(bclk == m_exp[1], "R3 R6 R7 R8 bit", bclk, m_exp[1]);
            check(frm  == m_exp[2], "R4 R5 R6 R7 R8 frame", frm, m_exp[2]);
            check(fam_out == m_fam, "R9 family", fam_out, m_fam);
        end
    end

    // Edge-count ratio checks while all outputs run.
    logic pm = 0, pbk = 0, pfr = 0;
    int   mcnt = 0, bcnt = 0;
    logic [1:0] win_mode = 0;
    bit   valid = 0;
    always @(negedge clk) begin
        if (!count_en) begin
            valid = 0; mcnt = 0; bcnt = 0;
        end else begin
            if (pm && !mclk) mcnt++;
            if (pbk && !bclk) begin
                bcnt++;
                if (valid) check(mcnt == bdiv(win_mode), "R3 master falls per bit", mcnt, bdiv(win_mode));
                mcnt = 0;
            end
            if (pfr && !frm) begin
                check(!bclk && !mclk, "R5 common fall", {mclk, bclk}, 0);
                if (valid) check(bcnt == 64, "R4 bit falls per frame", bcnt, 64);
                bcnt = 0;
                win_mode = m_mode;
                valid = 1;
            end
        end
        pm = mclk; pbk = bclk; pfr = frm;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; mode_drv = 2'b00; dis_drv = 3'b111; fam_drv = 2'b00;
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        check({mclk, bclk, frm} == 3'b000, "R1 outputs in reset", {mclk, bclk, frm}, 0);
        check(fam_out == 2'b00, "R1 family in reset", fam_out, 0);
        fam_drv = 2'b11;
        @(negedge clk);
        rst_n = 1;
        run_chk = 1;
        // R1/R6: outputs stay off after reset while disabled
        repeat (40) begin
            @(negedge clk);
            check({mclk, bclk, frm} == 3'b000, "R1 R6 off after reset", {mclk, bclk, frm}, 0);
        end
        // Directed: all enabled in each mode, including mid-frame mode requests
        dis_drv = 3'b000;
        count_en = 1;
        for (int md = 0; md < 4; md++) begin
            mode_drv = md[1:0];
            fam_drv  = md[1:0];
            repeat (2600) @(negedge clk);
        end
        count_en = 0;
        // Directed: rapid disable toggling to stress R7
        mode_drv = 2'b00;
        repeat (600) begin
            dis_drv = 3'($urandom_range(0, 7));
            repeat (3) @(negedge clk);
        end
        // Directed: disable one output at a time (R6)
        for (int k = 0; k < 3; k++) begin
            dis_drv = 3'b111 ^ (3'b001 << k);
            repeat (1200) @(negedge clk);
        end
        // Constrained random segments
        repeat (30) begin
            mode_drv = 2'($urandom_range(0, 3));
            dis_drv  = 3'($urandom_range(0, 7));
            fam_drv  = 2'($urandom_range(0, 3));
            repeat ($urandom_range(50, 2500)) @(negedge clk);
        end
        // Mid-run reset returns to the reset state (R1)
        rst_n = 0;
        @(negedge clk);
        check({mclk, bclk, frm} == 3'b000, "R1 outputs after late reset", {mclk, bclk, frm}, 0);
        finish_run();
    end

endmodule